// File: doc/BRIEF.md
# Stereo Serial Audio Output Port

This block takes a left/right pair of 24-bit samples, captured at the same instant, and sends it over a three-wire serial audio link. The link has a bit clock, a frame clock that marks which channel is on the line, and one data line. Each word is sent most significant bit first. All logic runs from the master clock `clk`.

When `slaveMode` is low, the port is the clock master. It divides `clk` by 4 to make the bit clock and by 256 to make the frame clock, so one frame holds 64 bit periods. When `slaveMode` is high, the bit and frame clocks come in from outside. They are synchronised into `clk`, their edges are detected, and the port follows them. The ratio of bit clock to frame rate may be anything from 48 to 128.

`i2sFormat` picks the framing. Low gives left-justified framing: the frame clock is high for the left channel and the MSB follows the frame-clock transition at once. High gives I2S framing: the frame clock is low for the left channel and the MSB comes one bit period after the transition. A new pair is presented with a one-cycle `sampleValid` strobe. The port holds it until the next start of a left half-frame.

Top module: `stereo_serial_tx`

## Requirements
- R1: Each channel word is 24 bits in two's complement, sent MSB first. A deserialiser at the far end recovers every bit unchanged.
- R2: With `slaveMode` low, `bclkOut` runs at `clk`/4. It is high for 2 cycles, then low for 2 cycles.
- R3: With `slaveMode` low, `lrclkOut` changes every 128 `clk` cycles, so its period is 256 cycles. It changes only in the same cycle in which `bclkOut` falls.
- R4: With `i2sFormat` low, the frame clock is high during the left word. Word bit 23 is in bit period 0 after each frame-clock transition, and bit 0 is in bit period 23.
- R5: With `i2sFormat` high, the frame clock is low during the left word. Bit period 0 after each transition carries 0, bit 23 is in bit period 1, and bit 0 is in bit period 24.
- R6: With `slaveMode` high, the port follows `bclkIn` and `lrclkIn` for half-frames of 24 to 64 bit periods (48x to 128x the frame rate). All 24 bits fit when a half-frame holds at least 24 bit periods (left-justified) or 25 bit periods (I2S). `bclkOut` and `lrclkOut` stay low in this mode.
- R7: `sdata` changes only after a falling edge of the active bit clock, within 2 + `SYNC_STAGES` cycles. It stays stable while the bit clock is high.
- R8: Every bit period in a half-frame that comes after the word is driven as 0.
- R9: A pair strobed in with `sampleValid` is latched as a whole at the next start of a left half-frame. A strobe that arrives during a frame does not change that frame's right word, so both words of a frame come from the same strobe.
- R10: While `rstN` is low, `sdata` and `bclkOut` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (256x frame rate in master mode) |
| rstN | input | 1 | Asynchronous reset, active low |
| slaveMode | input | 1 | 1: clocks come from inputs; 0: port generates clocks |
| i2sFormat | input | 1 | 1: I2S framing; 0: left-justified framing |
| sampleValid | input | 1 | One-cycle strobe that captures the sample pair |
| sampleLeft | input | 24 | Left sample, two's complement |
| sampleRight | input | 24 | Right sample, two's complement |
| bclkIn | input | 1 | Bit clock used in slave mode |
| lrclkIn | input | 1 | Frame clock used in slave mode |
| bclkOut | output | 1 | Generated bit clock (held low in slave mode) |
| lrclkOut | output | 1 | Generated frame clock (held low in slave mode) |
| sdata | output | 1 | Serial data, changes after bit-clock falling edges |

## Verification
A wrong slot counter or a wrong shift register puts bits in the wrong bit periods. A far-end deserialiser sees this as a corrupted word or a nonzero tail within the same half-frame. A frame-clock edge that is missed or comes late shows up as a wrong frame-clock period, or as words that slip by a whole frame, at the next left half-frame. If the port latched the pair at the wrong moment, the right word of a frame would mix with the newly strobed pair and show up one frame after the strobe.

// File: rtl/stereo_serial_tx_pkg.sv
package stereo_serial_tx_pkg;

  // Per-cycle events that the clock control sends to the shift path.
  typedef struct packed {
    logic bitFall;     // active bit clock fell in this cycle
    logic startLeft;   // frame clock entered the left half
    logic startRight;  // frame clock entered the right half
  } portStrobe_t;

endpackage

// File: rtl/stx_clock_ctrl.sv
module stx_clock_ctrl
  import stereo_serial_tx_pkg::*;
#(
  parameter int MCLK_PER_BCLK  = 4,    // power of two
  parameter int BCLK_PER_FRAME = 64,   // power of two
  parameter int SYNC_STAGES    = 2,
  parameter int MAX_HALF_SLOTS = 64,
  localparam int SLOT_W = $clog2(MAX_HALF_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              i2sFormat,
  input  logic              bclkIn,
  input  logic              lrclkIn,
  output logic              bclkOut,
  output logic              lrclkOut,
  output portStrobe_t       strobe,
  output logic [SLOT_W-1:0] slotCnt
);

  localparam int DIV_W = $clog2(MCLK_PER_BCLK);
  localparam int FRM_W = $clog2(BCLK_PER_FRAME);
  localparam int CNT_W = DIV_W + FRM_W;

  // Master-mode divider: the low bits give the bit clock and the top bit gives the half-frame.
  logic [CNT_W-1:0] divCnt;
  logic genBclk, genLr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divCnt <= '0;
    else if (slaveMode) divCnt <= '0;
    else                divCnt <= divCnt + 1'b1;
  end

  assign genBclk = divCnt[DIV_W-1];
  // The first half is the left channel; its frame-clock level depends on the framing.
  assign genLr   = divCnt[CNT_W-1] ^ ~i2sFormat;

  // Slave-mode synchronisers.
  logic slvBclk, slvLr;
  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] bSync, lSync;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bSync <= '0;
          lSync <= '0;
        end else begin
          bSync[0] <= bclkIn;
          lSync[0] <= lrclkIn;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            bSync[i] <= bSync[i-1];
            lSync[i] <= lSync[i-1];
          end
        end
      end
      assign slvBclk = bSync[SYNC_STAGES-1];
      assign slvLr   = lSync[SYNC_STAGES-1];
    end else begin : g_nosync
      assign slvBclk = bclkIn;
      assign slvLr   = lrclkIn;
    end
  endgenerate

  logic bclkSrc, lrSrc;
  assign bclkSrc  = slaveMode ? slvBclk : genBclk;
  assign lrSrc    = slaveMode ? slvLr   : genLr;
  assign bclkOut  = slaveMode ? 1'b0 : genBclk;
  assign lrclkOut = slaveMode ? 1'b0 : genLr;

  // Edge tracking, common to both modes.
  logic bclkPrev, lrPrev, primed;
  logic bitFall, lrChange, leftLevel;

  assign bitFall   = bclkPrev & ~bclkSrc;
  assign lrChange  = primed & (lrSrc != lrPrev);
  assign leftLevel = ~i2sFormat;

  always_comb begin
    strobe.bitFall    = bitFall;
    strobe.startLeft  = bitFall & lrChange & (lrSrc == leftLevel);
    strobe.startRight = bitFall & lrChange & (lrSrc != leftLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      lrPrev   <= 1'b0;
      primed   <= 1'b0;
      slotCnt  <= '0;
    end else begin
      bclkPrev <= bclkSrc;
      if (bitFall) begin
        if (!primed) begin
          primed <= 1'b1;
          lrPrev <= lrSrc;
        end else if (lrChange) begin
          lrPrev  <= lrSrc;
          slotCnt <= '0;
        end else if (slotCnt != '1) begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stx_shift_path.sv
module stx_shift_path
  import stereo_serial_tx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              i2sFormat,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleLeft,
  input  logic [WORD_W-1:0] sampleRight,
  input  portStrobe_t       strobe,
  output logic              sdata
);

  localparam int SHIFT_W = WORD_W + 1;

  logic [WORD_W-1:0]  pendLeft, pendRight, frameRight;
  logic [SHIFT_W-1:0] shiftReg;
  logic [SHIFT_W-1:0] loadLeft, loadRight;

  // I2S puts one zero bit before the MSB; left-justified puts the MSB first.
  function automatic logic [SHIFT_W-1:0] framePattern(input logic [WORD_W-1:0] word,
                                                      input logic i2s);
    return i2s ? {1'b0, word} : {word, 1'b0};
  endfunction

  assign loadLeft  = framePattern(pendLeft, i2sFormat);
  assign loadRight = framePattern(frameRight, i2sFormat);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLeft   <= '0;
      pendRight  <= '0;
      frameRight <= '0;
      shiftReg   <= '0;
      sdata      <= 1'b0;
    end else begin
      if (sampleValid) begin
        pendLeft  <= sampleLeft;
        pendRight <= sampleRight;
      end
      if (strobe.startLeft) begin
        frameRight <= pendRight;
        sdata      <= loadLeft[SHIFT_W-1];
        shiftReg   <= {loadLeft[SHIFT_W-2:0], 1'b0};
      end else if (strobe.startRight) begin
        sdata      <= loadRight[SHIFT_W-1];
        shiftReg   <= {loadRight[SHIFT_W-2:0], 1'b0};
      end else if (strobe.bitFall) begin
        sdata      <= shiftReg[SHIFT_W-1];
        shiftReg   <= {shiftReg[SHIFT_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import stereo_serial_tx_pkg::*;
#(
  parameter int WORD_W         = 24,
  parameter int MCLK_PER_BCLK  = 4,
  parameter int BCLK_PER_FRAME = 64,
  parameter int MAX_HALF_SLOTS = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              i2sFormat,
  input  logic              sampleValid,
  input  logic [WORD_W-1:0] sampleLeft,
  input  logic [WORD_W-1:0] sampleRight,
  input  logic              bclkIn,
  input  logic              lrclkIn,
  output logic              bclkOut,
  output logic              lrclkOut,
  output logic              sdata
);

  localparam int SLOT_W = $clog2(MAX_HALF_SLOTS);

  portStrobe_t       strobe;
  logic [SLOT_W-1:0] slotCnt;

  stx_clock_ctrl #(
    .MCLK_PER_BCLK (MCLK_PER_BCLK),
    .BCLK_PER_FRAME(BCLK_PER_FRAME),
    .SYNC_STAGES   (SYNC_STAGES),
    .MAX_HALF_SLOTS(MAX_HALF_SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slaveMode(slaveMode),
    .i2sFormat(i2sFormat),
    .bclkIn   (bclkIn),
    .lrclkIn  (lrclkIn),
    .bclkOut  (bclkOut),
    .lrclkOut (lrclkOut),
    .strobe   (strobe),
    .slotCnt  (slotCnt)
  );

  stx_shift_path #(
    .WORD_W(WORD_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .i2sFormat  (i2sFormat),
    .sampleValid(sampleValid),
    .sampleLeft (sampleLeft),
    .sampleRight(sampleRight),
    .strobe     (strobe),
    .sdata      (sdata)
  );

endmodule

// File: rtl/stereo_serial_tx_chk.sv
module stereo_serial_tx_chk
  import stereo_serial_tx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              slaveMode,
  input logic              i2sFormat,
  input logic              bclkOut,
  input logic              lrclkOut,
  input logic              sdata,
  input portStrobe_t       strobe,
  input logic [SLOT_W-1:0] slotCnt
);

  assert_data_after_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdata) |-> $past(strobe.bitFall));

  assert_lr_on_bclk_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && !$stable(lrclkOut)) |-> $fell(bclkOut));

  assert_bclk_high_two_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bclkOut) |=> bclkOut);

  assert_bclk_low_two_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bclkOut) |=> !bclkOut);

  assert_zero_tail_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(slotCnt) >= WORD_W + int'(i2sFormat)) |-> !sdata);

  assert_i2s_lead_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (i2sFormat && slotCnt == '0) |-> !sdata);

  assert_start_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.startLeft || strobe.startRight) |-> strobe.bitFall);

  assert_start_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startLeft, strobe.startRight}));

endmodule

bind stereo_serial_tx stereo_serial_tx_chk #(
  .WORD_W(WORD_W),
  .SLOT_W(SLOT_W)
) u_chk (.*);

// File: tb/stereo_serial_tx_tb.sv
module stereo_serial_tx_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0, slaveMode = 1'b0, i2sFormat = 1'b0, sampleValid = 1'b0;
  logic [23:0] sampleLeft = '0, sampleRight = '0;
  logic        bclkIn = 1'b0, lrclkIn = 1'b0;
  logic        bclkOut, lrclkOut, sdata;

  stereo_serial_tx u_dut (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .i2sFormat(i2sFormat),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdata(sdata)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Slave clock source
  bit slvRun = 0;
  int slvDiv = 8, slvSlots = 32, subCnt = 0, bitCnt = 0;
  initial forever begin
    @(posedge clk); #1;
    if (slvRun) begin
      if (subCnt == slvDiv - 1) begin
        subCnt = 0;
        if (bclkIn) begin
          bclkIn = 1'b0;
          bitCnt++;
          if (bitCnt == slvSlots) begin
            bitCnt = 0;
            lrclkIn = ~lrclkIn;
          end
        end else bclkIn = 1'b1;
      end else subCnt++;
    end
  end

  // Scoreboard state
  logic [47:0] expQ[$];
  logic [47:0] expPair;
  bit          monOn = 0, mPrimed, mKnown, mArmed, mHalfLeft, pbPrimed, plPrimed;
  logic        bObs, lObs, mLrLast, bPrevN, lPrevN, sPrevN, leftLvl;
  logic [23:0] gotL, gotR;
  int          mSlot, mTail, leftStarts, framesCmp, cyc, lastRise, lastLr;
  int          bPerErr, lPerErr, syncErr, outErr, r7Err;
  string       caseTag;

  always @(negedge clk) begin
    if (monOn) begin
      cyc++;
      bObs = slaveMode ? bclkIn  : bclkOut;
      lObs = slaveMode ? lrclkIn : lrclkOut;
      if (!slaveMode && lObs !== lPrevN && !(bPrevN && !bObs)) syncErr++;
      if (slaveMode && (bclkOut !== 1'b0 || lrclkOut !== 1'b0)) outErr++;
      if (sdata !== sPrevN && bObs && bPrevN) r7Err++;
      if (lObs !== lPrevN) begin
        if (plPrimed && !slaveMode && (cyc - lastLr) != 128) lPerErr++;
        lastLr = cyc; plPrimed = 1;
      end
      if (bObs && !bPrevN) begin
        if (pbPrimed && !slaveMode && (cyc - lastRise) != 4) bPerErr++;
        lastRise = cyc; pbPrimed = 1;
        if (!mPrimed) begin
          mPrimed = 1; mLrLast = lObs;
        end else if (lObs !== mLrLast) begin
          mLrLast = lObs; mKnown = 1; mSlot = 0;
          mHalfLeft = (lObs === leftLvl);
          if (mHalfLeft) begin
            if (mArmed) begin
              framesCmp++;
              check(gotL === expPair[47:24], {caseTag, " R1 left word"}, {24'h0, gotL}, {24'h0, expPair[47:24]});
              check(gotR === expPair[23:0], {caseTag, " R9 right word same pair"}, {24'h0, gotR}, {24'h0, expPair[23:0]});
              check(mTail == 0, {caseTag, " R8 zero tail"}, 48'(mTail), 48'h0);
            end
            if (expQ.size() > 0) begin
              expPair = expQ.pop_front(); mArmed = 1;
            end else mArmed = 0;
            gotL = '0; gotR = '0; mTail = 0;
            leftStarts++;
          end
        end else mSlot++;
        if (mKnown) begin
          if (mSlot >= int'(i2sFormat) && mSlot < int'(i2sFormat) + 24) begin
            if (mHalfLeft) gotL[23 - (mSlot - int'(i2sFormat))] = sdata;
            else           gotR[23 - (mSlot - int'(i2sFormat))] = sdata;
          end else if (sdata !== 1'b0) mTail++;
        end
      end
      bPrevN = bObs; lPrevN = lObs; sPrevN = sdata;
    end
  end

  function automatic logic [47:0] pairFor(input int k, input int seed);
    logic [23:0] a;
    case (k)
      0: return {24'h800000, 24'h7FFFFF};
      1: return {24'hFFFFFF, 24'h000001};
      2: return {24'h123456, 24'hABCDEF};
      default: begin
        a = 24'h2468AC + 24'(k * 977 + seed * 131);
        return {a, ~a ^ 24'h0F0F0F};
      end
    endcase
  endfunction

  task automatic runCase(input bit slv, input bit i2s, input int slots, input int nPairs,
                         input string tag, input int seed);
    int cur;
    monOn = 0; slvRun = 0; rstN = 1'b0;
    slaveMode = slv; i2sFormat = i2s; slvSlots = slots; subCnt = 0; bitCnt = 0;
    leftLvl = ~i2s; bclkIn = 1'b0; lrclkIn = ~i2s; sampleValid = 1'b0;
    expQ.delete(); caseTag = tag;
    mPrimed = 0; mKnown = 0; mArmed = 0; pbPrimed = 0; plPrimed = 0;
    mSlot = 0; mTail = 0; leftStarts = 0; framesCmp = 0; cyc = 0;
    bPerErr = 0; lPerErr = 0; syncErr = 0; outErr = 0; r7Err = 0;
    bPrevN = 1'b0; lPrevN = slv ? ~i2s : ~i2s; sPrevN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sdata === 1'b0 && bclkOut === 1'b0, {tag, " R10 reset outputs"}, {46'h0, bclkOut, sdata}, 48'h0);
    @(posedge clk); #1;
    rstN = 1'b1; slvRun = slv; monOn = 1;
    while (leftStarts < 1) @(posedge clk);
    for (int k = 0; k < nPairs; k++) begin
      repeat (20) @(posedge clk);
      #1;
      {sampleLeft, sampleRight} = pairFor(k, seed);
      sampleValid = 1'b1;
      expQ.push_back(pairFor(k, seed));
      @(posedge clk); #1;
      sampleValid = 1'b0;
      cur = leftStarts;
      while (leftStarts == cur) @(posedge clk);
    end
    cur = leftStarts;
    while (leftStarts == cur) @(posedge clk);
    monOn = 0; slvRun = 0;
    check(framesCmp == nPairs, {tag, " R9 frames compared"}, 48'(framesCmp), 48'(nPairs));
    check(r7Err == 0, {tag, " R7 data stable while bit clock high"}, 48'(r7Err), 48'h0);
    if (!slv) begin
      check(bPerErr == 0, {tag, " R2 bit clock period"}, 48'(bPerErr), 48'h0);
      check(lPerErr == 0 && syncErr == 0, {tag, " R3 frame clock period and alignment"},
            48'(lPerErr + syncErr), 48'h0);
    end else begin
      check(outErr == 0, {tag, " R6 clock outputs low"}, 48'(outErr), 48'h0);
    end
  endtask

  initial begin
    runCase(1'b0, 1'b0, 32, 4, "R4 master left-justified", 1);
    runCase(1'b0, 1'b1, 32, 4, "R5 master i2s", 2);
    runCase(1'b1, 1'b0, 32, 3, "R6 slave 64x left-justified", 3);
    runCase(1'b1, 1'b1, 32, 3, "R6 slave 64x i2s", 4);
    runCase(1'b1, 1'b0, 24, 3, "R6 slave 48x left-justified", 5);
    runCase(1'b1, 1'b1, 64, 3, "R6 slave 128x i2s", 6);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired in %s", caseTag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule